// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable stand-in for a 16 Kbit serial EEPROM on a three-wire bus. The pins are chip select, serial clock, data in and a data out that can float. It holds 1024 words of 16 bits in a register array. A host selects the device and clocks in a start bit, a two-bit opcode, a ten-bit address and, for some commands, a sixteen-bit data word. The device answers reads serially on the data output. A write-enable latch guards every command that changes storage. Each accepted modifying command runs a self-timed internal cycle. That cycle starts once chip select has been low long enough, and the host can watch busy or ready on the data output.

The pins are sampled through two-stage synchronizers on the system clock. Serial clock rising edges are found on the synchronized copy. A state machine steps through these states: IDLE (wait for start bit), HDR (shift opcode and address), DATA (shift data word), READ (shift stored word out), ARM (command done, wait for deselect), DESEL (count the deselect time), BUSY (internal cycle) and READY (cycle done, ready shown).

The transitions are as follows. IDLE or READY go to HDR on a start bit. HDR goes to READ, DATA or ARM on its last bit. DATA goes to ARM on its last bit. HDR, DATA and READ go back to IDLE when chip select drops. ARM goes to DESEL on deselect if an operation is pending, and to IDLE otherwise. DESEL goes to IDLE if chip select returns early, and to BUSY once the count is reached. BUSY goes to READY when the timer expires.

Top module: `mw_eeprom_model`

## Requirements
- R1: After reset the write-enable latch is clear, every word reads 0xFFFF and the data output is not driven.
- R2: A command begins, with chip select high, at the first data-in 1 sampled on a serial clock rise; 0 bits before it are ignored. It continues with 2 opcode bits and 10 address bits, MSB first. Opcodes: 10 read, 01 write, 11 erase, 00 extended. For extended, address bits [9:8] select 00 write-disable, 01 write-all, 10 erase-all, 11 write-enable.
- R3: After the last address bit of a read, the output drives a 0 dummy bit and then the 16 stored bits MSB first, one per serial clock rise. This works whatever the latch state.
- R4: With the latch clear, write, erase, write-all and erase-all change no word and start no cycle, so no status appears.
- R5: The latch stays set across completed writes until a write-disable command clears it.
- R6: A write shifts 16 data bits MSB first after the address and stores them at the address during the cycle.
- R7: Erase sets the addressed word to 0xFFFF and leaves the other words untouched.
- R8: Write-all stores the data word in every location, and erase-all sets every word to 0xFFFF.
- R9: The cycle starts only after chip select has stayed low for TCS_MIN system clocks past the end of the command. If chip select returns high sooner, the command is discarded.
- R10: With chip select high, the output drives 0 while the cycle runs and drives 1 after it ends, until the next start bit. With chip select low the output is not driven.
- R11: Serial traffic during a running cycle is ignored.
- R12: A command cut off by chip select falling before its last bit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock |
| di | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out value |
| do_oe | output | 1 | Data out drive enable (0 = high impedance) |

## Verification
The assertions check on every cycle that the output floats while deselected, that status during BUSY and READY is 0 and 1, and that storage is written only with the latch set. They also check that the latch falls only while a header is decoded, that BUSY is entered only from DESEL and that BUSY cannot be left before its timer ends. Stored contents can only be shown by the bench's scenarios, which compare serial reads against a behavioural memory model. The same applies to the gating of write-disable, bulk fills, the discard of short deselects and cut-off commands, and the ignoring of traffic during the cycle.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR,
        S_DATA,
        S_READ,
        S_ARM,
        S_DESEL,
        S_BUSY,
        S_READY
    } mw_state_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_WRITE,
        K_ERASE,
        K_WRAL,
        K_ERAL
    } mw_kind_e;

    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    localparam logic [1:0] EX_DIS   = 2'b00;
    localparam logic [1:0] EX_WRAL  = 2'b01;
    localparam logic [1:0] EX_ERAL  = 2'b10;
    localparam logic [1:0] EX_EN    = 2'b11;

endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic cs_s,
    output logic di_s,
    output logic sk_rise
);
    logic [2:0] meta_q;
    logic [2:0] sync_q;
    logic       sk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q  <= '0;
            sync_q  <= '0;
            sk_prev <= 1'b0;
        end else begin
            meta_q  <= {cs, sk, di};
            sync_q  <= meta_q;
            sk_prev <= sync_q[1];
        end
    end

    assign cs_s    = sync_q[2];
    assign di_s    = sync_q[0];
    assign sk_rise = sync_q[1] & ~sk_prev;
endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] wa,
    input  logic [DATA_W-1:0] wd,
    input  logic [ADDR_W-1:0] ra,
    output logic [DATA_W-1:0] rd
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= '1;
            end
        end else if (we) begin
            mem[wa] <= wd;
        end
    end

    assign rd = mem[ra];
endmodule

// File: rtl/mw_cycle_timer.sv
module mw_cycle_timer #(
    parameter int CYC  = 1500,
    parameter int TC_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic [TC_W-1:0] cnt,
    output logic            done
);
    logic running;

    assign done = running && (cnt == TC_W'(CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (start) begin
            cnt     <= '0;
            running <= 1'b1;
        end else if (running) begin
            if (done) begin
                running <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mw_eeprom_model.sv
module mw_eeprom_model
    import mw_eeprom_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 16,
    parameter int TCS_MIN = 8,
    parameter int TWC     = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic do_o,
    output logic do_oe
);
    localparam int WORDS = 1 << ADDR_W;
    localparam int HDR_W = ADDR_W + 2;
    localparam int BC_W  = $clog2(HDR_W + DATA_W);
    localparam int DC_W  = $clog2(TCS_MIN + 1);
    localparam int CYC   = (TWC > WORDS) ? TWC : WORDS + 1;
    localparam int TC_W  = $clog2(CYC + 1);

    logic              cs_s, di_s, sk_rise;
    mw_state_e         state, state_d;
    mw_kind_e          kind;
    logic [HDR_W-1:0]  hdr, hdr_nx;
    logic [1:0]        op, ext;
    logic [ADDR_W-1:0] hdr_addr, addr, wa;
    logic [BC_W-1:0]   bcnt;
    logic [DATA_W-1:0] wdata, rsh, rd_data, wd;
    logic [DC_W-1:0]   dcnt;
    logic [TC_W-1:0]   tcnt;
    logic              rbit, wel;
    logic              hdr_last, data_last, start_bit;
    logic              tmr_start, tmr_done, mem_we, all_mode;

    mw_pin_sync u_sync (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .cs_s(cs_s), .di_s(di_s), .sk_rise(sk_rise)
    );

    mw_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .wa(wa), .wd(wd),
        .ra(hdr_addr), .rd(rd_data)
    );

    mw_cycle_timer #(.CYC(CYC), .TC_W(TC_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .cnt(tcnt), .done(tmr_done)
    );

    // header decode on the bit being shifted in now
    assign hdr_nx    = {hdr[HDR_W-2:0], di_s};
    assign op        = hdr_nx[HDR_W-1 -: 2];
    assign hdr_addr  = hdr_nx[ADDR_W-1:0];
    assign ext       = hdr_addr[ADDR_W-1 -: 2];
    assign hdr_last  = sk_rise && (bcnt == BC_W'(HDR_W - 1));
    assign data_last = sk_rise && (bcnt == BC_W'(DATA_W - 1));
    assign start_bit = cs_s && sk_rise && di_s;

    // next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            S_IDLE, S_READY: begin
                if (start_bit) state_d = S_HDR;
            end
            S_HDR: begin
                if (!cs_s) begin
                    state_d = S_IDLE;
                end else if (hdr_last) begin
                    if (op == OP_READ)
                        state_d = S_READ;
                    else if (op == OP_WRITE || (op == OP_EXT && ext == EX_WRAL))
                        state_d = S_DATA;
                    else
                        state_d = S_ARM;
                end
            end
            S_DATA: begin
                if (!cs_s)          state_d = S_IDLE;
                else if (data_last) state_d = S_ARM;
            end
            S_READ: begin
                if (!cs_s) state_d = S_IDLE;
            end
            S_ARM: begin
                if (!cs_s) state_d = (kind == K_NONE) ? S_IDLE : S_DESEL;
            end
            S_DESEL: begin
                if (cs_s)                                state_d = S_IDLE;
                else if (dcnt == DC_W'(TCS_MIN - 1))     state_d = S_BUSY;
            end
            S_BUSY: begin
                if (tmr_done) state_d = S_READY;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_d;
    end

    // shift registers, latch and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr   <= '0;
            bcnt  <= '0;
            wdata <= '0;
            rsh   <= '0;
            rbit  <= 1'b0;
            wel   <= 1'b0;
            kind  <= K_NONE;
            addr  <= '0;
            dcnt  <= '0;
        end else begin
            case (state)
                S_IDLE, S_READY: begin
                    if (start_bit) begin
                        hdr  <= '0;
                        bcnt <= '0;
                    end
                end
                S_HDR: begin
                    if (sk_rise) begin
                        hdr  <= hdr_nx;
                        bcnt <= bcnt + 1'b1;
                        if (hdr_last) begin
                            bcnt <= '0;
                            addr <= hdr_addr;
                            rsh  <= rd_data;
                            rbit <= 1'b0;
                            kind <= K_NONE;
                            case (op)
                                OP_WRITE: kind <= K_WRITE;
                                OP_ERASE: kind <= wel ? K_ERASE : K_NONE;
                                OP_EXT: begin
                                    case (ext)
                                        EX_DIS:  wel  <= 1'b0;
                                        EX_EN:   wel  <= 1'b1;
                                        EX_WRAL: kind <= K_WRAL;
                                        EX_ERAL: kind <= wel ? K_ERAL : K_NONE;
                                    endcase
                                end
                                default: ;
                            endcase
                        end
                    end
                end
                S_DATA: begin
                    if (sk_rise) begin
                        wdata <= {wdata[DATA_W-2:0], di_s};
                        bcnt  <= bcnt + 1'b1;
                        if (data_last && !wel) kind <= K_NONE;
                    end
                end
                S_READ: begin
                    if (sk_rise) begin
                        rbit <= rsh[DATA_W-1];
                        rsh  <= {rsh[DATA_W-2:0], 1'b0};
                    end
                end
                S_ARM:   dcnt <= '0;
                S_DESEL: dcnt <= dcnt + 1'b1;
                default: ;
            endcase
        end
    end

    // internal cycle: single word on its first clock, bulk sweep one word per clock
    assign tmr_start = (state == S_DESEL) && (state_d == S_BUSY);
    assign all_mode  = (kind == K_WRAL) || (kind == K_ERAL);
    assign mem_we    = (state == S_BUSY) &&
                       (all_mode ? (tcnt < TC_W'(WORDS)) : (tcnt == '0));
    assign wa        = all_mode ? tcnt[ADDR_W-1:0] : addr;
    assign wd        = (kind == K_ERASE || kind == K_ERAL) ? '1 : wdata;

    // output process
    always_comb begin
        do_oe = cs_s && (state == S_READ || state == S_BUSY || state == S_READY);
        do_o  = (state == S_READ) ? rbit : (state == S_READY);
    end
endmodule

// File: rtl/mw_eeprom_checker.sv
module mw_eeprom_checker
    import mw_eeprom_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cs_s,
    input mw_state_e state,
    input logic      wel,
    input logic      mem_we,
    input logic      tmr_done,
    input logic      do_o,
    input logic      do_oe
);
    p_hiz_deselected_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |-> !do_oe);

    p_busy_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BUSY && cs_s) |-> (do_oe && !do_o));

    p_ready_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READY && cs_s) |-> (do_oe && do_o));

    p_store_needs_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wel);

    p_latch_drop_from_header_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wel) |-> ($past(state) == S_HDR));

    p_cycle_after_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BUSY && $past(state) != S_BUSY) |-> ($past(state) == S_DESEL));

    p_busy_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BUSY && !tmr_done) |=> (state == S_BUSY));
endmodule

bind mw_eeprom_model mw_eeprom_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .state(state), .wel(wel),
    .mem_we(mem_we), .tmr_done(tmr_done), .do_o(do_o), .do_oe(do_oe)
);

// File: tb/mw_eeprom_model_bench.sv
module mw_eeprom_model_bench;
    localparam int CLK_P    = 10;
    localparam int ADDR_W   = 10;
    localparam int DATA_W   = 16;
    localparam int TCS_MIN  = 8;
    localparam int TWC      = 1500;
    localparam int WORDS    = 1 << ADDR_W;
    localparam int WD_LIMIT = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic do_o, do_oe;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int lowcnt = 0;
    bit finished = 1'b0;

    logic [DATA_W-1:0] ref_mem [WORDS];
    bit ref_wel;

    always #(CLK_P/2) clk = ~clk;

    mw_eeprom_model #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TCS_MIN(TCS_MIN), .TWC(TWC))
        u_mw_eeprom_model (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .do_o(do_o), .do_oe(do_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(input logic b);
        di = b;
        tick(2);
        sk = 1'b1;
        tick(4);
        sk = 1'b0;
        tick(4);
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [ADDR_W-1:0] a, input int lead);
        cs = 1'b1;
        tick(4);
        repeat (lead) put_bit(1'b0);
        put_bit(1'b1);
        for (int i = 1; i >= 0; i--) put_bit(op[i]);
        for (int i = ADDR_W-1; i >= 0; i--) put_bit(a[i]);
    endtask

    task automatic send_data(input logic [DATA_W-1:0] d, input int nbits);
        for (int i = DATA_W-1; i >= DATA_W-nbits; i--) put_bit(d[i]);
    endtask

    task automatic finish_cmd;
        cs = 1'b0;
        tick(6);
    endtask

    // after chip select fell at the end of a modifying command
    task automatic run_cycle(input string req, input bit expect_busy);
        tick(20);
        cs = 1'b1;
        tick(4);
        if (expect_busy) begin
            chk(do_oe === 1'b1 && do_o === 1'b0, "R10", "busy status",
                {30'd0, do_oe, do_o}, 32'h2);
            tick(TWC + 10);
            chk(do_oe === 1'b1 && do_o === 1'b1, "R10", "ready status",
                {30'd0, do_oe, do_o}, 32'h3);
        end else begin
            chk(do_oe === 1'b0, req, "no status without cycle", {31'd0, do_oe}, 32'h0);
        end
        cs = 1'b0;
        tick(6);
    endtask

    task automatic ext_cmd(input logic [1:0] sel);
        send_hdr(2'b00, {sel, 8'h00}, 0);
        finish_cmd();
        if (sel == 2'b11) ref_wel = 1'b1;
        if (sel == 2'b00) ref_wel = 1'b0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input string req);
        send_hdr(2'b01, a, 0);
        send_data(d, DATA_W);
        cs = 1'b0;
        if (ref_wel) ref_mem[a] = d;
        run_cycle(req, ref_wel);
    endtask

    task automatic erase(input logic [ADDR_W-1:0] a);
        send_hdr(2'b11, a, 0);
        cs = 1'b0;
        if (ref_wel) ref_mem[a] = '1;
        run_cycle("R7", ref_wel);
    endtask

    task automatic fill_all(input bit is_erase, input logic [DATA_W-1:0] d);
        if (is_erase) begin
            send_hdr(2'b00, {2'b10, 8'h00}, 0);
        end else begin
            send_hdr(2'b00, {2'b01, 8'h00}, 0);
            send_data(d, DATA_W);
        end
        cs = 1'b0;
        if (ref_wel) for (int i = 0; i < WORDS; i++) ref_mem[i] = is_erase ? '1 : d;
        run_cycle("R8", ref_wel);
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input string req, input int lead);
        logic [DATA_W-1:0] got;
        send_hdr(2'b10, a, lead);
        chk(do_oe === 1'b1 && do_o === 1'b0, "R3", "dummy bit", {30'd0, do_oe, do_o}, 32'h2);
        for (int i = DATA_W-1; i >= 0; i--) begin
            sk = 1'b1;
            tick(4);
            got[i] = do_o;
            sk = 1'b0;
            tick(4);
        end
        chk(got === ref_mem[a], req, $sformatf("read word %0d", a), {16'd0, got}, {16'd0, ref_mem[a]});
        finish_cmd();
    endtask

    // per-clock comparison: output must float once chip select has been low a while (R10)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (cs === 1'b0) lowcnt++;
            else             lowcnt = 0;
            if (lowcnt >= 3)
                chk(do_oe === 1'b0, "R10", "float while deselected", {31'd0, do_oe}, 32'h0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=%0d expected<%0d", cyc, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < WORDS; i++) ref_mem[i] = '1;
        ref_wel = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        chk(do_oe === 1'b0, "R1", "output floats after reset", {31'd0, do_oe}, 32'h0);
        rd(5, "R1", 0);

        // latch clear after reset: write ignored (R4)
        wr(3, 16'h1234, "R4");
        rd(3, "R4", 0);
        erase(3);
        rd(3, "R4", 0);

        ext_cmd(2'b11);
        wr(3, 16'h1234, "R6");
        rd(3, "R6", 2);                 // leading zeros before start bit (R2)
        wr(1023, 16'hABCD, "R5");       // latch still set after previous write
        rd(1023, "R5", 0);
        rd(0, "R2", 0);

        erase(3);
        rd(3, "R7", 0);
        rd(1023, "R7", 0);

        fill_all(1'b0, 16'h5A5A);
        rd(0, "R8", 0);
        rd(512, "R8", 0);
        rd(1023, "R8", 0);
        fill_all(1'b1, 16'h0000);
        rd(0, "R8", 0);
        rd(1023, "R8", 0);

        wr(100, 16'h00C3, "R6");

        // short deselect discards the command (R9)
        send_hdr(2'b01, 9, 0);
        send_data(16'h1111, DATA_W);
        cs = 1'b0;
        tick(3);
        cs = 1'b1;
        tick(6);
        chk(do_oe === 1'b0, "R9", "no cycle after short deselect", {31'd0, do_oe}, 32'h0);
        finish_cmd();
        rd(9, "R9", 0);

        // command cut off mid-data (R12)
        send_hdr(2'b01, 30, 0);
        send_data(16'h3C3C, 8);
        finish_cmd();
        rd(30, "R12", 0);

        // traffic during a running cycle is ignored (R11)
        send_hdr(2'b01, 20, 0);
        send_data(16'h0F0F, DATA_W);
        cs = 1'b0;
        ref_mem[20] = 16'h0F0F;
        tick(20);
        send_hdr(2'b01, 20, 0);
        send_data(16'h1111, DATA_W);
        chk(do_oe === 1'b1 && do_o === 1'b0, "R11", "still busy during traffic",
            {30'd0, do_oe, do_o}, 32'h2);
        cs = 1'b0;
        tick(TWC + 10);
        rd(20, "R11", 0);

        // write-disable then write ignored, reads still work (R5, R3)
        ext_cmd(2'b00);
        wr(7, 16'h7777, "R5");
        rd(7, "R5", 0);
        rd(100, "R3", 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule